// File: doc/BRIEF.md
# SPI Status and Command Front End for a Serial Memory

This block is the device-side command controller of a serial non-volatile memory attached to an SPI host in mode 0. While chip select is low it shifts an 8-bit opcode in, most significant bit first, on rising serial clock edges. It then acts on the opcode. It sets or clears the write-enable latch, returns the status byte, or accepts a new status byte. Array read and array write opcodes are only flagged to an external array engine with a one-cycle pulse.

The block keeps the status byte, with the busy flag, the write-enable latch, two protection bits and a status-lock bit. A status write that commits starts an internal write cycle of parameterised length, counted in system clocks. The busy flag reads 1 for that whole cycle, and the host can poll the status byte throughout it.

The serial inputs are sampled in the system clock domain. They must already be synchronous to `clk_i`. Each serial clock phase must last at least three system clocks.

Top module: `spi_mem_cmd_ctrl`

## Requirements
- R1: Opcodes are taken MSB first from the first 8 rising serial clock edges after chip select falls. 0x06 sets the write-enable latch, 0x04 clears it, 0x05 reads status, 0x01 writes status, 0x03 reads the array and 0x02 writes the array.
- R2: The status byte has the lock bit at bit 7, protect bit B at bit 3, protect bit A at bit 2, the write-enable latch at bit 1 and the busy flag at bit 0. Bits 6 to 4 read 0. All bits are 0 after reset.
- R3: After 0x06 or 0x04 executes, further serial clocks in the same selection have no effect.
- R4: A status read returns the status byte MSB first. Each bit changes on a falling serial clock edge, with the first bit after the 8th opcode fall. The byte repeats for as long as clocks continue.
- R5: A status write commits only when chip select rises after exactly 16 rising edges. With 15 or 17 edges the status stays unchanged.
- R6: Status write and array write are ignored while the write-enable latch is 0.
- R7: The busy flag and the write-enable latch ignore the data byte of a status write.
- R8: The busy flag reads 1 for WRITE_CYCLES system clocks from the committing chip-select rise. The write-enable latch clears when the cycle ends.
- R9: During the write cycle, the lock and protect bits read their old values. The new values appear once the cycle ends.
- R10: While busy, every opcode other than 0x05 is ignored, including 0x04 and 0x03.
- R11: The output enable is 1 only while status bits are being shifted in a selected status read.
- R12: `array_rd_o` pulses on a decoded 0x03. `array_wr_o` pulses on a decoded 0x02 only when the write-enable latch is 1.
- R13: Raising chip select clears a partially received opcode, so the next selection decodes from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock, synchronous to clk_i |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data in |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for miso_o (0 means high impedance) |
| array_rd_o | output | 1 | One-cycle pulse: array read decoded |
| array_wr_o | output | 1 | One-cycle pulse: permitted array write decoded |

## Verification
A wrong bit count or a wrong commit condition shows in the next status read as protect bits that changed when they should not, or failed to change when they should. A wrong write-cycle timer moves the point where the busy bit in a polled byte falls. A status read started a few clocks before or after the expected end catches this within one byte. Frozen-bit or read-only errors show in the first status byte polled during a cycle. A wrong output enable or array pulse is visible on the same clock.

// File: rtl/spi_mem_cmd_pkg.sv
package spi_mem_cmd_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OP_WEL_SET  = 8'h06;
  localparam logic [BYTE_W-1:0] OP_WEL_CLR  = 8'h04;
  localparam logic [BYTE_W-1:0] OP_STAT_RD  = 8'h05;
  localparam logic [BYTE_W-1:0] OP_STAT_WR  = 8'h01;
  localparam logic [BYTE_W-1:0] OP_ARRAY_RD = 8'h03;
  localparam logic [BYTE_W-1:0] OP_ARRAY_WR = 8'h02;

  typedef enum logic [1:0] {
    ST_OPCODE,
    ST_WSTAT_DATA,
    ST_STAT_OUT,
    ST_SKIP
  } cmd_state_e;

  typedef struct packed {
    logic lock;
    logic prot_b;
    logic prot_a;
  } nv_bits_t;

  function automatic logic [BYTE_W-1:0] pack_status(nv_bits_t nv, logic wel, logic wip);
    return {nv.lock, 3'b000, nv.prot_b, nv.prot_a, wel, wip};
  endfunction
endpackage

// File: rtl/spi_bit_front.sv
module spi_bit_front
  import spi_mem_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              sclk_fall_o,
  output logic              cs_rise_o,
  output logic              byte_vld_o,
  output logic              byte_idx_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              frame_full_o
);
  localparam int unsigned CNT_MAX = 2 * BYTE_W + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LAST0 = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] LAST1 = CNT_W'(2 * BYTE_W - 1);
  localparam logic [CNT_W-1:0] FRAME = CNT_W'(2 * BYTE_W);
  localparam logic [CNT_W-1:0] CSAT  = CNT_W'(CNT_MAX);

  logic              sclk_q, cs_q, sclk_rise;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
    end
  end

  assign sclk_rise   = sclk_i & ~sclk_q & ~cs_ni;
  assign sclk_fall_o = ~sclk_i & sclk_q & ~cs_ni;
  assign cs_rise_o   = cs_ni & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      shift_q    <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
      byte_idx_o <= 1'b0;
    end else if (cs_ni) begin
      cnt_q      <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;
      if (sclk_rise) begin
        shift_q <= {shift_q[BYTE_W-2:0], mosi_i};
        if (cnt_q != CSAT) cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST0 || cnt_q == LAST1) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {shift_q[BYTE_W-2:0], mosi_i};
          byte_idx_o <= (cnt_q == LAST1);
        end
      end
    end
  end

  assign frame_full_o = (cnt_q == FRAME);

  // R1: a completed byte is reported for one cycle only
  a_r1_byte_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |=> !byte_vld_o);
endmodule

// File: rtl/spi_status_file.sv
module spi_status_file
  import spi_mem_cmd_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_wel_i,
  input  logic              clr_wel_i,
  input  logic              commit_i,
  input  nv_bits_t          wdata_i,
  output logic [BYTE_W-1:0] status_o,
  output logic              busy_o,
  output logic              wel_o
);
  localparam int unsigned TW = $clog2(WRITE_CYCLES + 1);
  localparam logic [TW-1:0] TLOAD = TW'(WRITE_CYCLES - 1);

  nv_bits_t      nv_q, pend_q;
  logic          wel_q, wip_q;
  logic [TW-1:0] timer_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nv_q    <= '0;
      pend_q  <= '0;
      wel_q   <= 1'b0;
      wip_q   <= 1'b0;
      timer_q <= '0;
    end else if (wip_q) begin
      if (timer_q == '0) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
        nv_q  <= pend_q;  // new values surface only at cycle end
      end else begin
        timer_q <= timer_q - 1'b1;
      end
    end else if (commit_i) begin
      wip_q   <= 1'b1;
      timer_q <= TLOAD;
      pend_q  <= wdata_i;
    end else if (set_wel_i) begin
      wel_q <= 1'b1;
    end else if (clr_wel_i) begin
      wel_q <= 1'b0;
    end
  end

  assign status_o = pack_status(nv_q, wel_q, wip_q);
  assign busy_o   = wip_q;
  assign wel_o    = wel_q;

  a_r8_busy_from_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(commit_i));
  a_r9_nv_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_q |-> $stable(nv_q));
  a_r8_wel_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q);
  a_r6_commit_needs_wel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |-> wel_q);
endmodule

// File: rtl/spi_status_tx.sv
module spi_status_tx
  import spi_mem_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              sclk_fall_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic              miso_o
);
  localparam int unsigned IDX_W = $clog2(BYTE_W);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(BYTE_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] snap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= IDX_TOP;
      snap_q <= '0;
      miso_o <= 1'b0;
    end else if (!active_i) begin
      idx_q  <= IDX_TOP;
      miso_o <= 1'b0;
    end else if (sclk_fall_i) begin
      idx_q <= idx_q - 1'b1;  // wraps to the top bit for the next repeat
      if (idx_q == IDX_TOP) begin
        snap_q <= status_i;   // whole byte from one instant
        miso_o <= status_i[BYTE_W-1];
      end else begin
        miso_o <= snap_q[idx_q];
      end
    end
  end

  // R4: first bit of each repeated byte is the live lock bit
  a_r4_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && sclk_fall_i && idx_q == IDX_TOP) |=> (miso_o == $past(status_i[BYTE_W-1])));
endmodule

// File: rtl/spi_mem_cmd_ctrl.sv
module spi_mem_cmd_ctrl
  import spi_mem_cmd_pkg::*;
#(
  parameter int unsigned WRITE_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic array_rd_o,
  output logic array_wr_o
);
  logic              sclk_fall, cs_rise, byte_vld, byte_idx, frame_full;
  logic [BYTE_W-1:0] rx_byte, status;
  logic              busy, wel, set_wel, clr_wel, commit, dec_fire;
  cmd_state_e        state_q, state_d;

  spi_bit_front u_front (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_fall_o (sclk_fall),
    .cs_rise_o   (cs_rise),
    .byte_vld_o  (byte_vld),
    .byte_idx_o  (byte_idx),
    .byte_o      (rx_byte),
    .frame_full_o(frame_full)
  );

  assign dec_fire = !cs_ni && state_q == ST_OPCODE && byte_vld && !byte_idx;

  always_comb begin
    state_d    = state_q;
    set_wel    = 1'b0;
    clr_wel    = 1'b0;
    array_rd_o = 1'b0;
    array_wr_o = 1'b0;
    if (dec_fire) begin
      state_d = ST_SKIP;
      if (rx_byte == OP_STAT_RD) begin
        state_d = ST_STAT_OUT;
      end else if (!busy) begin
        case (rx_byte)
          OP_WEL_SET:  set_wel = 1'b1;
          OP_WEL_CLR:  clr_wel = 1'b1;
          OP_STAT_WR:  if (wel) state_d = ST_WSTAT_DATA;
          OP_ARRAY_RD: array_rd_o = 1'b1;
          OP_ARRAY_WR: array_wr_o = wel;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= ST_OPCODE;
    else if (cs_ni) state_q <= ST_OPCODE;
    else            state_q <= state_d;
  end

  // commit only on a deselect landing exactly after the data byte
  assign commit = cs_rise && state_q == ST_WSTAT_DATA && frame_full;

  spi_status_file #(.WRITE_CYCLES(WRITE_CYCLES)) u_status (
    .clk_i, .rst_ni,
    .set_wel_i(set_wel),
    .clr_wel_i(clr_wel),
    .commit_i (commit),
    .wdata_i  ('{lock: rx_byte[7], prot_b: rx_byte[3], prot_a: rx_byte[2]}),
    .status_o (status),
    .busy_o   (busy),
    .wel_o    (wel)
  );

  assign miso_oe_o = (state_q == ST_STAT_OUT) && !cs_ni;

  spi_status_tx u_tx (
    .clk_i, .rst_ni,
    .active_i   (miso_oe_o),
    .sclk_fall_i(sclk_fall),
    .status_i   (status),
    .miso_o     (miso_o)
  );

  a_r11_oe_off_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !miso_oe_o);
  a_r12_wr_pulse_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_wr_o |-> wel);
  a_r10_busy_skips: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_fire && busy && rx_byte != OP_STAT_RD) |=> state_q == ST_SKIP);
  a_r12_rd_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    array_rd_o |-> !busy);
endmodule

// File: tb/spi_mem_cmd_ctrl_bench.sv
module spi_mem_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int WC = 1000;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, arr_rd, arr_wr;
  int n_cmp = 0, n_bad = 0, cyc = 0, rd_cnt = 0, wr_cnt = 0, t_desel = 0;
  logic last_oe;
  logic m_lock, m_wel;
  logic [1:0] m_prot;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_rd) rd_cnt <= rd_cnt + 1;
    if (arr_wr) wr_cnt <= wr_cnt + 1;
  end

  spi_mem_cmd_ctrl #(.WRITE_CYCLES(WC)) u_spi_mem_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .array_rd_o(arr_rd), .array_wr_o(arr_wr)
  );

  function automatic logic [7:0] exp_stat(logic lock, logic [1:0] prot, logic wel, logic wip);
    return {lock, 3'b000, prot, wel, wip};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    mosi = b;
    tick(HALF);
    r = miso;
    last_oe = miso_oe;
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) xbit(tx[i], rx[i]);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic desel();
    tick(HALF);
    cs_n = 1'b1;
    t_desel = cyc;
    tick(HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx;
    sel();
    xbyte(op, rx);
    desel();
  endtask

  task automatic rdsr(output logic [7:0] s1, output logic [7:0] s2, output logic oe);
    logic [7:0] rx;
    sel();
    xbyte(8'h05, rx);
    xbyte(8'h00, s1);
    oe = last_oe;
    xbyte(8'h00, s2);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] d, input int nbits);
    logic [7:0] rx;
    logic r;
    sel();
    xbyte(8'h01, rx);
    for (int i = 0; i < nbits - 8; i++) xbit((i < 8) ? d[7-i] : 1'b0, r);
    desel();
  endtask

  task automatic check_model(input string req);
    logic [7:0] s1, s2;
    logic oe;
    rdsr(s1, s2, oe);
    chk(req, s1, exp_stat(m_lock, m_prot, m_wel, 1'b0));
  endtask

  initial begin
    logic [7:0] s1, s2, d;
    logic oe, r;
    int k, rd0, wr0;
    int unsigned rv;
    void'($urandom(32'h0000_5a17));
    m_lock = 0; m_prot = 0; m_wel = 0;
    tick(3);
    rst_ni = 1'b1;
    tick(3);
    chk("R11 oe idle after reset", miso_oe, 0);
    rdsr(s1, s2, oe);
    chk("R2 reset status", s1, 8'h00);
    chk("R4 repeated byte", s2, 8'h00);
    chk("R11 oe during status", oe, 1);
    chk("R11 oe after deselect", miso_oe, 0);

    // R13: partial opcode then deselect
    sel();
    for (int i = 0; i < 4; i++) xbit(1'b1, r);
    desel();
    cmd(8'h06);
    rdsr(s1, s2, oe);
    chk("R13/R1 set latch after partial opcode", s1, 8'h02);

    // R3: bits after 0x06 ignored (would be a status write otherwise)
    cmd(8'h04);
    sel();
    xbyte(8'h06, s1);
    xbyte(8'h01, s1);
    xbyte(8'hFF, s1);
    desel();
    tick(20);
    rdsr(s1, s2, oe);
    chk("R3 trailing clocks ignored", s1, 8'h02);
    cmd(8'h04);
    rdsr(s1, s2, oe);
    chk("R3 clear latch", s1, 8'h00);

    // R6: without latch
    wrsr(8'h8C, 16);
    tick(20);
    rdsr(s1, s2, oe);
    chk("R6 status write without latch", s1, 8'h00);
    wr0 = wr_cnt; rd0 = rd_cnt;
    cmd(8'h02);
    chk("R6 array write without latch", wr_cnt - wr0, 0);
    cmd(8'h03);
    chk("R12 array read pulse", rd_cnt - rd0, 1);
    cmd(8'h06);
    cmd(8'h02);
    chk("R12 array write pulse", wr_cnt - wr0, 1);

    // R5: wrong frame lengths
    wrsr(8'hFF, 17);
    tick(20);
    rdsr(s1, s2, oe);
    chk("R5 17 edges aborted", s1, 8'h02);
    wrsr(8'hFF, 15);
    tick(20);
    rdsr(s1, s2, oe);
    chk("R5 15 edges aborted", s1, 8'h02);

    // committed write, polled during the cycle
    wrsr(8'hFF, 16);
    k = t_desel;
    rdsr(s1, s2, oe);
    chk("R9/R7 frozen bits while busy", s1, 8'h03);
    chk("R4 polling repeats while busy", s2, 8'h03);
    rd0 = rd_cnt;
    cmd(8'h04);
    cmd(8'h03);
    chk("R10 array read ignored while busy", rd_cnt - rd0, 0);
    rdsr(s1, s2, oe);
    chk("R10 latch clear ignored while busy", s1, 8'h03);
    wait_until(k + WC - 70);
    rdsr(s1, s2, oe);
    chk("R8 still busy before end", s1, 8'h03);
    tick(40);
    rdsr(s1, s2, oe);
    chk("R8/R9/R7 after cycle", s1, 8'h8C);

    // R8: just after the end
    cmd(8'h06);
    wrsr(8'h00, 16);
    k = t_desel;
    wait_until(k + WC - 66);
    rdsr(s1, s2, oe);
    chk("R8 idle right after end", s1, 8'h00);

    // random mix
    m_lock = 0; m_prot = 0; m_wel = 0;
    for (int it = 0; it < 16; it++) begin
      rv = $urandom;
      d = 8'($urandom);
      case (rv[1:0])
        2'd0: begin
          cmd(8'h06); wrsr(d, 16); tick(WC + 10);
          m_lock = d[7]; m_prot = d[3:2]; m_wel = 0;
        end
        2'd1: begin
          cmd(8'h04); wrsr(d, 16); tick(20); m_wel = 0;
        end
        2'd2: begin
          cmd(8'h06); wrsr(d, rv[2] ? 17 : 15); tick(20); m_wel = 1;
        end
        default: begin
          if (rv[3]) begin cmd(8'h06); m_wel = 1; end
          else begin cmd(8'h04); m_wel = 0; end
        end
      endcase
      check_model("R5/R6 random sequence");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule